// File: doc/BRIEF.md
# Oversampled Serial Output Formatter

This block takes one left and one right sample per output word and shifts both out at the same time, MSB first, on two separate data lines. It also produces the bit clock and the word clock that go with them. The receiver samples data on the rising edge of the bit clock and latches a whole word on the falling edge of the word clock.

The frame has a fixed length for each clock mode, whatever the data length. With `frame_sel` low a word lasts 24 bit periods, and with it high a word lasts 32. The number of data bits (16, 18 or 20) only sets how many leading slots carry data; the slots after the LSB are driven low. An optional DC offset of about 0.8 % of full scale can be added to each sample. The sum saturates at the largest positive value instead of wrapping.

The `clk` input runs at twice the output bit rate, so one bit period is always two `clk` cycles. Pulling `mute_n` low forces both data lines low at once, while both clocks keep running. After `mute_n` returns high, the outputs stay silent until the third rising edge of the sample-rate clock `fs_clk`. On that edge the frame timing is realigned, and a new word starts on the next `clk` edge. The synchronous reset `rst` leaves the block in the muted state.

Top module: `ovs_serializer`

## Requirements
- R1: One bit period is two `clk` cycles: `bclk` is low in the first and high in the second. A word lasts 24 bit periods when `frame_sel` is 0 and 32 when `frame_sel` is 1. `frame_sel` is changed only while the output is muted.
- R2: `wclk` is low for the first (word length − 6) bit periods of each word and high for the last 6. Its falling edge coincides with the first bit period of a word.
- R3: While the output is not muted, `dout_l`, `dout_r` and `wclk` change only on a falling edge of `bclk`.
- R4: Slot 0 of a word carries the MSB, followed by the lower bits in order. After the last data bit, the remaining slots are 0. `len_sel` gives the data length: 0 = 16 bits, 1 = 18 bits, 2 or 3 = 20 bits.
- R5: `smp_l` and `smp_r` are 20-bit two's complement values. The N-bit word sent is the sample shifted right arithmetically by 20 − N.
- R6: With `ofs_en` high, a value of 512 is added to a 16-bit word, 2048 to an 18-bit word and 8192 to a 20-bit word, each counted in output LSBs.
- R7: If adding the offset would exceed the largest positive N-bit value, that largest value is sent instead.
- R8: Both channels are sent in the same slots, and each carries its own sample.
- R9: While `mute_n` is low, `dout_l` and `dout_r` are 0 in the same cycle, and `bclk` and `wclk` keep toggling.
- R10: After `mute_n` returns high, both data lines stay 0 through the first two rising edges of `fs_clk`. The third rising edge (sampled on `clk`) unmutes the output and realigns the timing. On the following `clk` edge, `bclk` falls, `wclk` is low and the MSB of a new word appears.
- R11: `smp_l`, `smp_r`, `len_sel` and `ofs_en` are captured on the edge that starts a word. Changing them during the word has no effect on that word.
- R12: While `rst` is high, `bclk`, `wclk`, `dout_l` and `dout_r` are 0. After `rst` the block is muted and needs three `fs_clk` rises, as in R10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the output bit rate |
| rst | input | 1 | Synchronous reset, active high |
| mute_n | input | 1 | Mute request, active low |
| fs_clk | input | 1 | Sample-rate clock; its rising edges release mute |
| frame_sel | input | 1 | 0: 24 bit periods per word, 1: 32 bit periods |
| len_sel | input | 2 | Data length: 0 = 16, 1 = 18, 2/3 = 20 bits |
| ofs_en | input | 1 | Add the saturating DC offset |
| smp_l | input | 20 | Left sample, two's complement |
| smp_r | input | 20 | Right sample, two's complement |
| bclk | output | 1 | Output bit clock |
| wclk | output | 1 | Output word clock |
| dout_l | output | 1 | Left serial data |
| dout_r | output | 1 | Right serial data |

## Verification
Every combination of frame mode, data length and offset enable is tried with the same set of samples: zero, minus one, the largest and smallest 20-bit values, a value just below positive full scale, and an irregular mixed-bit value. Zero and minus one show whether the offset is applied and how the sign is carried into the word. The full-scale value and the value just below it show saturation against wrap-around, and the most negative value shows that nothing saturates on the negative side. The mixed value shows whether bits are in the right order and whether truncation drops the correct low bits. The left and right channels always carry different samples, which exposes any crossing of the channels. New samples are applied right after each word starts, which checks that words are captured only at the start. Separate passes mute the output in the middle of a word and reset the block during operation, then count the `fs_clk` rises needed before the output comes back.

// File: rtl/ovs_pkg.sv
package ovs_pkg;

    localparam int SMP_W        = 20;
    localparam int FRAME_A      = 24;
    localparam int FRAME_B      = 32;
    localparam int TAIL         = 6;
    localparam int RESYNC_EDGES = 3;
    localparam int IDX_W        = $clog2(FRAME_B);
    localparam int CNT_W        = $clog2(RESYNC_EDGES + 1);
    // offset at full sample width; truncation scales it to the shorter lengths
    localparam int OFS_VAL      = 1 << (SMP_W - 7);

    typedef logic signed [SMP_W-1:0] smp_t;

    typedef enum logic [1:0] {
        LEN16  = 2'd0,
        LEN18  = 2'd1,
        LEN20  = 2'd2,
        LEN20X = 2'd3
    } len_e;

    function automatic int unsigned drop_bits(len_e l);
        case (l)
            LEN16:   return 4;
            LEN18:   return 2;
            default: return 0;
        endcase
    endfunction

    // saturating offset at full width, then clear the dropped low bits
    function automatic smp_t fmt_sample(smp_t s, len_e l, logic ofs);
        smp_t sum;
        smp_t sat;
        smp_t keep;
        sum = s + (ofs ? smp_t'(OFS_VAL) : smp_t'(0));
        if (!s[SMP_W-1] && sum[SMP_W-1])
            sat = {1'b0, {(SMP_W-1){1'b1}}};
        else
            sat = sum;
        keep = ~((smp_t'(1) << drop_bits(l)) - smp_t'(1));
        return sat & keep;
    endfunction

endpackage

// File: rtl/ovs_timing.sv
module ovs_timing
    import ovs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic frame_sel,
    input  logic resync,
    output logic bclk,
    output logic wclk,
    output logic word_start,
    output logic bit_adv
);

    logic             ph;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] idx_nx;
    logic [IDX_W-1:0] last;
    logic [IDX_W-1:0] tail_start;

    always_comb begin
        last       = frame_sel ? IDX_W'(FRAME_B - 1) : IDX_W'(FRAME_A - 1);
        tail_start = last - IDX_W'(TAIL - 1);
        idx_nx     = (idx >= last) ? '0 : idx + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph   <= 1'b0;
            idx  <= '0;
            wclk <= 1'b0;
        end else if (resync) begin
            ph  <= 1'b1;
            idx <= last;
        end else if (ph) begin
            ph   <= 1'b0;
            idx  <= idx_nx;
            wclk <= (idx_nx >= tail_start);
        end else begin
            ph <= 1'b1;
        end
    end

    assign bclk       = ph;
    assign bit_adv    = ph & ~resync;
    assign word_start = ph & ~resync & (idx_nx == '0);

endmodule

// File: rtl/ovs_mute_seq.sv
module ovs_mute_seq
    import ovs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic mute_n,
    input  logic fs_clk,
    output logic muted,
    output logic resync
);

    logic             fs_q;
    logic             fs_rise;
    logic [CNT_W-1:0] rises;

    assign fs_rise = fs_clk & ~fs_q;
    assign resync  = mute_n & muted & fs_rise & (rises == CNT_W'(RESYNC_EDGES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            fs_q  <= 1'b0;
            muted <= 1'b1;
            rises <= '0;
        end else begin
            fs_q <= fs_clk;
            if (!mute_n) begin
                muted <= 1'b1;
                rises <= '0;
            end else if (resync) begin
                muted <= 1'b0;
                rises <= '0;
            end else if (muted && fs_rise) begin
                rises <= rises + 1'b1;
            end
        end
    end

endmodule

// File: rtl/ovs_chan_shift.sv
module ovs_chan_shift
    import ovs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic load,
    input  logic adv,
    input  smp_t word_in,
    output logic bit_out
);

    smp_t sh;

    always_ff @(posedge clk) begin
        if (rst || clr)
            sh <= '0;
        else if (load)
            sh <= word_in;
        else if (adv)
            sh <= {sh[SMP_W-2:0], 1'b0};
    end

    assign bit_out = sh[SMP_W-1];

endmodule

// File: rtl/ovs_serializer.sv
module ovs_serializer
    import ovs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             mute_n,
    input  logic             fs_clk,
    input  logic             frame_sel,
    input  logic [1:0]       len_sel,
    input  logic             ofs_en,
    input  logic [SMP_W-1:0] smp_l,
    input  logic [SMP_W-1:0] smp_r,
    output logic             bclk,
    output logic             wclk,
    output logic             dout_l,
    output logic             dout_r
);

    localparam int NCH = 2;

    logic           muted;
    logic           resync;
    logic           word_start;
    logic           bit_adv;
    smp_t           ch_in  [NCH];
    smp_t           ch_fmt [NCH];
    logic [NCH-1:0] ch_bit;

    ovs_mute_seq u_mute (
        .clk    (clk),
        .rst    (rst),
        .mute_n (mute_n),
        .fs_clk (fs_clk),
        .muted  (muted),
        .resync (resync)
    );

    ovs_timing u_tim (
        .clk        (clk),
        .rst        (rst),
        .frame_sel  (frame_sel),
        .resync     (resync),
        .bclk       (bclk),
        .wclk       (wclk),
        .word_start (word_start),
        .bit_adv    (bit_adv)
    );

    assign ch_in[0] = smp_l;
    assign ch_in[1] = smp_r;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        always_comb ch_fmt[c] = fmt_sample(ch_in[c], len_e'(len_sel), ofs_en);

        ovs_chan_shift u_sh (
            .clk     (clk),
            .rst     (rst),
            .clr     (resync),
            .load    (word_start),
            .adv     (bit_adv),
            .word_in (ch_fmt[c]),
            .bit_out (ch_bit[c])
        );
    end

    assign dout_l = ch_bit[0] & ~muted & mute_n;
    assign dout_r = ch_bit[1] & ~muted & mute_n;

endmodule

// File: rtl/ovs_serializer_chk.sv
module ovs_serializer_chk (
    input logic clk,
    input logic rst,
    input logic mute_n,
    input logic bclk,
    input logic wclk,
    input logic dout_l,
    input logic dout_r
);

    // R9: a low mute request silences both lines
    p_mute_low_r9: assert property (@(posedge clk) disable iff (rst)
        !mute_n |-> (!dout_l && !dout_r));

    // R3: the word clock moves only with a falling bit clock
    p_wclk_on_fall_r3: assert property (@(posedge clk) disable iff (rst)
        $changed(wclk) |-> $fell(bclk));

    // R3: unmuted data moves only with a falling bit clock
    p_data_on_fall_r3: assert property (@(posedge clk) disable iff (rst)
        (mute_n && $past(mute_n) && ($changed(dout_l) || $changed(dout_r)))
        |-> $fell(bclk));

    // R1: the low half of a bit period is one clock long
    p_bclk_low_one_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(bclk) |=> bclk);

endmodule

bind ovs_serializer ovs_serializer_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .mute_n (mute_n),
    .bclk   (bclk),
    .wclk   (wclk),
    .dout_l (dout_l),
    .dout_r (dout_r)
);

// File: tb/ovs_serializer_tb.sv
module ovs_serializer_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mute_n = 1'b0;
    logic        fs_clk = 1'b0;
    logic        frame_sel = 1'b0;
    logic [1:0]  len_sel = 2'd0;
    logic        ofs_en = 1'b0;
    logic [19:0] smp_l = '0;
    logic [19:0] smp_r = '0;
    logic        bclk, wclk, dout_l, dout_r;

    int checks = 0;
    int failures = 0;

    localparam logic [19:0] VALS [6] = '{20'h00000, 20'hFFFFF, 20'h7FFFF,
                                        20'h80000, 20'h7F123, 20'h2A5C3};

    always #(CLK_PERIOD/2) clk = ~clk;

    ovs_serializer u_dut (
        .clk       (clk),
        .rst       (rst),
        .mute_n    (mute_n),
        .fs_clk    (fs_clk),
        .frame_sel (frame_sel),
        .len_sel   (len_sel),
        .ofs_en    (ofs_en),
        .smp_l     (smp_l),
        .smp_r     (smp_r),
        .bclk      (bclk),
        .wclk      (wclk),
        .dout_l    (dout_l),
        .dout_r    (dout_r)
    );

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // slot k of the word is bit k of the result
    function automatic logic [31:0] exp_slots(input logic [19:0] s,
                                              input logic [1:0] ls, input bit ofs);
        int n;
        int v;
        logic [31:0] r;
        n = (ls == 2'd0) ? 16 : (ls == 2'd1) ? 18 : 20;
        v = $signed(s);
        v = v >>> (20 - n);
        if (ofs) v = v + (512 << (n - 16));
        if (v > (1 << (n - 1)) - 1) v = (1 << (n - 1)) - 1;
        r = '0;
        for (int k = 0; k < n; k++) r[k] = v[n-1-k];
        return r;
    endfunction

    task automatic sync_start();
        logic pw;
        pw = wclk;
        forever begin
            @(negedge clk);
            if (pw === 1'b1 && wclk === 1'b0) break;
            pw = wclk;
        end
    endtask

    // entered at the first sample point of a word, leaves at the next one
    task automatic grab(input logic [19:0] el, input logic [19:0] er);
        int W;
        logic [31:0] cl, cr, el_s, er_s;
        bit fr_ok;
        W = frame_sel ? 32 : 24;
        cl = '0; cr = '0; fr_ok = 1'b1;
        for (int k = 0; k < W; k++) begin
            if (bclk !== 1'b0) fr_ok = 1'b0;
            if (wclk !== (k >= W - 6)) fr_ok = 1'b0;
            cl[k] = dout_l;
            cr[k] = dout_r;
            @(negedge clk);
            if (bclk !== 1'b1 || dout_l !== cl[k] || dout_r !== cr[k]) fr_ok = 1'b0;
            @(negedge clk);
        end
        if (wclk !== 1'b0 || bclk !== 1'b0) fr_ok = 1'b0;
        chk(fr_ok, "R1 R2 R3 frame shape", {31'd0, fr_ok}, 32'd1);
        el_s = exp_slots(el, len_sel, ofs_en);
        er_s = exp_slots(er, len_sel, ofs_en);
        chk(cl === el_s, "R4 R5 R6 R7 R11 left word", cl, el_s);
        chk(cr === er_s, "R8 R4 R5 R6 R7 right word", cr, er_s);
    endtask

    // samples must already be on the inputs; ends at a word's first sample point
    task automatic release_mute();
        bit quiet;
        int toggles;
        logic pb;
        logic [31:0] el_s, er_s;
        quiet = 1'b1; toggles = 0;
        mute_n = 1'b1;
        pb = bclk;
        for (int r = 0; r < 2; r++) begin
            fs_clk = 1'b1;
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                if (dout_l !== 1'b0 || dout_r !== 1'b0) quiet = 1'b0;
                if (bclk !== pb) toggles++;
                pb = bclk;
            end
            fs_clk = 1'b0;
            for (int i = 0; i < 5; i++) begin
                @(negedge clk);
                if (dout_l !== 1'b0 || dout_r !== 1'b0) quiet = 1'b0;
                if (bclk !== pb) toggles++;
                pb = bclk;
            end
        end
        chk(quiet && toggles > 4, "R10 silent before third rise", {31'd0, quiet}, 32'd1);
        fs_clk = 1'b1;
        @(negedge clk);
        chk(bclk === 1'b1, "R10 bclk high at resync", {31'd0, bclk}, 32'd1);
        @(negedge clk);
        el_s = exp_slots(smp_l, len_sel, ofs_en);
        er_s = exp_slots(smp_r, len_sel, ofs_en);
        chk(bclk === 1'b0 && wclk === 1'b0 && dout_l === el_s[0] && dout_r === er_s[0],
            "R10 word starts after resync",
            {28'd0, bclk, wclk, dout_l, dout_r}, {30'd0, el_s[0], er_s[0]});
        fs_clk = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin : main
        bit ok;
        int bt, wt;
        logic pb, pw;

        // R12: reset state
        smp_l = 20'h5A5A5; smp_r = 20'hA5A5A;
        repeat (3) @(negedge clk);
        chk(bclk === 0 && wclk === 0 && dout_l === 0 && dout_r === 0,
            "R12 reset state", {28'd0, bclk, wclk, dout_l, dout_r}, 32'd0);
        rst = 1'b0;
        mute_n = 1'b1;
        ok = 1'b1;
        repeat (100) begin
            @(negedge clk);
            if (dout_l !== 0 || dout_r !== 0) ok = 1'b0;
        end
        chk(ok, "R12 muted after reset", {31'd0, ok}, 32'd1);

        // full sweep of mode, length and offset
        for (int f = 0; f < 2; f++) begin
            for (int l = 0; l < 4; l++) begin
                for (int o = 0; o < 2; o++) begin
                    @(negedge clk);
                    mute_n = 1'b0;
                    #1;
                    frame_sel = f[0]; len_sel = l[1:0]; ofs_en = o[0];
                    smp_l = VALS[0]; smp_r = VALS[3];
                    ok = 1'b1;
                    repeat (20) begin
                        @(negedge clk);
                        if (dout_l !== 0 || dout_r !== 0) ok = 1'b0;
                    end
                    chk(ok, "R9 held low while muted", {31'd0, ok}, 32'd1);
                    release_mute();
                    for (int j = 0; j < 6; j++) begin
                        logic [19:0] cl_v, cr_v;
                        cl_v = VALS[j];
                        cr_v = VALS[(j + 3) % 6];
                        // R11: inputs change right after the word was captured
                        smp_l = VALS[(j + 1) % 6];
                        smp_r = VALS[(j + 4) % 6];
                        grab(cl_v, cr_v);
                    end
                end
            end
        end

        // R9: mute in the middle of operation
        frame_sel = 1'b0; len_sel = 2'd2; ofs_en = 1'b0;
        smp_l = 20'hFFFFF; smp_r = 20'hFFFFF;
        sync_start();
        sync_start();
        chk(dout_l === 1'b1, "R9 line high before mute", {31'd0, dout_l}, 32'd1);
        mute_n = 1'b0;
        #1;
        chk(dout_l === 1'b0 && dout_r === 1'b0, "R9 immediate mute",
            {30'd0, dout_l, dout_r}, 32'd0);
        ok = 1'b1; bt = 0; wt = 0; pb = bclk; pw = wclk;
        repeat (64) begin
            @(negedge clk);
            if (dout_l !== 0 || dout_r !== 0) ok = 1'b0;
            if (bclk !== pb) bt++;
            if (wclk !== pw) wt++;
            pb = bclk; pw = wclk;
        end
        chk(ok && bt == 64 && wt >= 2, "R9 clocks run while muted", bt, 32'd64);

        // R12: reset during operation leaves the block muted
        mute_n = 1'b1;
        smp_l = 20'h12345; smp_r = 20'h6789A;
        release_mute();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        ok = 1'b1;
        repeat (60) begin
            @(negedge clk);
            if (dout_l !== 0 || dout_r !== 0) ok = 1'b0;
        end
        chk(ok, "R12 muted after mid-run reset", {31'd0, ok}, 32'd1);
        release_mute();
        grab(20'h12345, 20'h6789A);

        summary();
    end

endmodule